// File: doc/BRIEF.md
# Flow-Slice Path Dispatcher

This block sits at the ingress of a switch that has several parallel internal paths. For every arriving packet it takes a flow identifier and a byte length, and it chooses the internal path the packet travels. Order within a flow is kept without sequence numbers and without a resequencer. A flow may change path only after it has been idle for longer than a programmable slicing threshold. By then the packets it sent earlier have drained, so a later packet cannot overtake an earlier one.

Each flow is hashed into a small on-chip table. An entry holds the full flow identifier, the timestamp of the flow's most recent packet and the path that packet used. A packet that finds no matching entry, or that arrives after a gap longer than the threshold, starts a new slice. A new slice goes to the path with the fewest outstanding bytes. A packet inside an ongoing slice follows its predecessor. Per-path byte counters rise on dispatch and fall on departure pulses reported by each path. A lost packet never stalls later traffic, because no state waits for a missing packet.

Top module: `fslice_dispatch`

## Requirements
- R1: While `rst` is high, and in the cycle after the first rising edge at which it is sampled high, `in_ready` is 0, `out_valid` is 0 and every path load reads 0. After reset, `in_ready` is 1 and the table holds no flows: the first packet of any flow starts a slice.
- R2: A packet is accepted at a rising edge where `in_valid` and `in_ready` are both 1. Its decision is on `out_valid`/`out_path`/`out_slice_start` in the following cycle only. `out_valid` is 0 in any cycle that follows an edge without acceptance.
- R3: A packet that starts a slice is sent to the path whose load is smallest when it is accepted, with ties going to the lowest path index. `out_slice_start` is 1 for it.
- R4: A packet whose flow identifier matches the table entry, and whose gap since that flow's previous packet is at most `slice_thresh` ticks, goes to the stored path with `out_slice_start` = 0. This holds however heavy that path's load is, and it holds for packets of one flow accepted in consecutive cycles.
- R5: A gap larger than `slice_thresh` starts a new slice. The gap is the accept-time timestamp minus the stored timestamp, and the timestamp advances by one each cycle after reset. The threshold input may be changed between packets and takes effect for the next accepted packet.
- R6: The table index is the XOR fold of the flow identifier: index bit j is the XOR of all identifier bits i with i mod IDX_W = j. An entry that holds a different identifier counts as a miss; the packet starts a slice and replaces that entry.
- R7: On acceptance, the chosen path's load rises by `in_len` at that edge. Other paths change only through their own departures.
- R8: A departure pulse on path p lowers that load by its length. If the result would be negative, the load becomes 0. A departure and a dispatch on the same path in one cycle combine as add-then-subtract.
- R9: The gap is computed modulo 2^TS_W, so a gap that spans the timestamp wrap is measured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet descriptor offered |
| in_ready | output | 1 | Block can accept a descriptor |
| in_flow | input | FLOW_W | Flow identifier |
| in_len | input | LEN_W | Packet length in bytes |
| slice_thresh | input | TS_W | Idle gap in ticks beyond which a flow re-slices |
| dep_valid | input | NUM_PATHS | Departure pulse, one bit per path |
| dep_len | input | NUM_PATHS*LEN_W | Departed length per path, path p at bits p*LEN_W upward |
| out_valid | output | 1 | Decision valid |
| out_path | output | clog2(NUM_PATHS) | Chosen internal path |
| out_slice_start | output | 1 | Packet opened a new slice |
| path_load | output | NUM_PATHS*LOAD_W | Outstanding bytes per path, path p at bits p*LOAD_W upward |

## Verification
A corrupted table entry shows up in the very next decision for that flow. Either a slice start appears where none is due, or a continuing packet lands on a different path than its predecessor, and both are visible on the outputs one cycle after acceptance. A wrong load counter is visible on `path_load` right after the edge. It also misdirects the next slice start, so a reference model of the loads and of each flow's last time and path catches it within one packet. Threshold and wrap faults are exposed by sending packets exactly at gaps equal to and one above the threshold, and across the timestamp rollover.

// File: rtl/fslice_pkg.sv
package fslice_pkg;

    // Upper bounds for width-agnostic helpers
    localparam int MAX_FLOW_W = 64;
    localparam int MAX_IDX_W  = 16;

    // Why a packet was (or was not) given a fresh slice
    typedef enum logic [1:0] {
        SL_CONT  = 2'd0,   // same flow, gap within threshold
        SL_MISS  = 2'd1,   // entry empty
        SL_ALIAS = 2'd2,   // entry owned by another flow
        SL_IDLE  = 2'd3    // flow idle longer than threshold
    } slice_cause_e;

    // XOR fold: bit (i mod idx_w) of the result accumulates flow bit i
    function automatic logic [MAX_IDX_W-1:0] fold_hash(
        input logic [MAX_FLOW_W-1:0] flow,
        input int                    flow_w,
        input int                    idx_w
    );
        logic [MAX_IDX_W-1:0] h;
        h = '0;
        for (int i = 0; i < MAX_FLOW_W; i++) begin
            if (i < flow_w) begin
                h = h ^ (MAX_IDX_W'(flow[i]) << (i % idx_w));
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/fslice_timebase.sv
module fslice_timebase #(
    parameter int TS_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] ts
);
    // Free-running tick counter; wraps naturally modulo 2^TS_W
    always_ff @(posedge clk) begin
        if (rst) begin
            ts <= '0;
        end else begin
            ts <= ts + 1'b1;
        end
    end
endmodule

// File: rtl/fslice_flow_table.sv
module fslice_flow_table #(
    parameter int FLOW_W = 32,
    parameter int IDX_W  = 6,
    parameter int TS_W   = 20,
    parameter int PATH_W = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_live,
    output logic [FLOW_W-1:0] rd_tag,
    output logic [TS_W-1:0]   rd_stamp,
    output logic [PATH_W-1:0] rd_path,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [FLOW_W-1:0] wr_tag,
    input  logic [TS_W-1:0]   wr_stamp,
    input  logic [PATH_W-1:0] wr_path
);
    typedef struct packed {
        logic [FLOW_W-1:0] tag;
        logic [TS_W-1:0]   stamp;
        logic [PATH_W-1:0] path;
    } slot_t;

    slot_t            slot_q [DEPTH];
    logic [DEPTH-1:0] live_q;
    slot_t            rd_slot;

    // Only the occupancy bits need reset; payload is qualified by them
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (wr_en) begin
            live_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_idx] <= '{tag: wr_tag, stamp: wr_stamp, path: wr_path};
        end
    end

    // Flop-based storage: a write at an edge is seen by the read after it
    assign rd_slot  = slot_q[rd_idx];
    assign rd_live  = live_q[rd_idx];
    assign rd_tag   = rd_slot.tag;
    assign rd_stamp = rd_slot.stamp;
    assign rd_path  = rd_slot.path;
endmodule

// File: rtl/fslice_path_load.sv
module fslice_path_load #(
    parameter int NUM_PATHS = 4,
    parameter int LEN_W     = 14,
    parameter int LOAD_W    = 24,
    parameter int PATH_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          add_en,
    input  logic [PATH_W-1:0]             add_path,
    input  logic [LEN_W-1:0]              add_len,
    input  logic [NUM_PATHS-1:0]          dep_valid,
    input  logic [NUM_PATHS*LEN_W-1:0]    dep_len,
    output logic [NUM_PATHS*LOAD_W-1:0]   load_flat,
    output logic [PATH_W-1:0]             min_path
);
    logic [LOAD_W-1:0] load_q [NUM_PATHS];

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_ctr
        logic [LOAD_W:0]   up;
        logic [LOAD_W:0]   down;
        logic [LOAD_W:0]   nxt;

        always_comb begin
            up = {1'b0, load_q[p]};
            if (add_en && (add_path == PATH_W'(p))) begin
                up = up + (LOAD_W+1)'(add_len);
            end
            down = dep_valid[p] ? (LOAD_W+1)'(dep_len[p*LEN_W +: LEN_W]) : '0;
            // add first, then retire; never below zero
            nxt = (up >= down) ? (up - down) : '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                load_q[p] <= '0;
            end else if (nxt[LOAD_W]) begin
                load_q[p] <= '1;
            end else begin
                load_q[p] <= nxt[LOAD_W-1:0];
            end
        end

        assign load_flat[p*LOAD_W +: LOAD_W] = load_q[p];
    end

    // Linear argmin; strict less-than keeps the lowest index on ties
    always_comb begin
        logic [LOAD_W-1:0] best_load;
        min_path  = '0;
        best_load = load_q[0];
        for (int q = 1; q < NUM_PATHS; q++) begin
            if (load_q[q] < best_load) begin
                best_load = load_q[q];
                min_path  = PATH_W'(q);
            end
        end
    end
endmodule

// File: rtl/fslice_dispatch.sv
module fslice_dispatch
    import fslice_pkg::*;
#(
    parameter int NUM_PATHS = 4,
    parameter int FLOW_W    = 32,
    parameter int LEN_W     = 14,
    parameter int LOAD_W    = 24,
    parameter int IDX_W     = 6,
    parameter int TS_W      = 20,
    localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [FLOW_W-1:0]           in_flow,
    input  logic [LEN_W-1:0]            in_len,
    input  logic [TS_W-1:0]             slice_thresh,
    input  logic [NUM_PATHS-1:0]        dep_valid,
    input  logic [NUM_PATHS*LEN_W-1:0]  dep_len,
    output logic                        out_valid,
    output logic [PATH_W-1:0]           out_path,
    output logic                        out_slice_start,
    output logic [NUM_PATHS*LOAD_W-1:0] path_load
);
    typedef struct packed {
        logic              vld;
        logic              start;
        logic [PATH_W-1:0] path;
    } verdict_t;

    logic                  rdy_q;
    logic                  accept;
    logic [TS_W-1:0]       now_ts;
    logic [MAX_FLOW_W-1:0] flow_ext;
    logic [MAX_IDX_W-1:0]  idx_wide;
    logic [IDX_W-1:0]      idx;
    logic                  rd_live;
    logic [FLOW_W-1:0]     rd_tag;
    logic [TS_W-1:0]       rd_stamp;
    logic [PATH_W-1:0]     rd_path;
    logic [TS_W-1:0]       gap;
    slice_cause_e          cause;
    logic                  fresh;
    logic [PATH_W-1:0]     lightest;
    logic [PATH_W-1:0]     pick;
    verdict_t              verdict_q;

    // Ready once reset has been sampled low
    always_ff @(posedge clk) begin
        rdy_q <= !rst;
    end
    assign in_ready = rdy_q;
    assign accept   = in_valid && rdy_q;

    fslice_timebase #(.TS_W(TS_W)) u_time (
        .clk (clk),
        .rst (rst),
        .ts  (now_ts)
    );

    always_comb begin
        flow_ext = '0;
        flow_ext[FLOW_W-1:0] = in_flow;
    end
    assign idx_wide = fold_hash(flow_ext, FLOW_W, IDX_W);
    assign idx      = idx_wide[IDX_W-1:0];

    fslice_flow_table #(
        .FLOW_W (FLOW_W),
        .IDX_W  (IDX_W),
        .TS_W   (TS_W),
        .PATH_W (PATH_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_live  (rd_live),
        .rd_tag   (rd_tag),
        .rd_stamp (rd_stamp),
        .rd_path  (rd_path),
        .wr_en    (accept),
        .wr_idx   (idx),
        .wr_tag   (in_flow),
        .wr_stamp (now_ts),
        .wr_path  (pick)
    );

    // Modular elapsed time survives the counter wrap
    assign gap = now_ts - rd_stamp;

    always_comb begin
        if (!rd_live) begin
            cause = SL_MISS;
        end else if (rd_tag != in_flow) begin
            cause = SL_ALIAS;
        end else if (gap > slice_thresh) begin
            cause = SL_IDLE;
        end else begin
            cause = SL_CONT;
        end
    end

    assign fresh = (cause != SL_CONT);
    assign pick  = fresh ? lightest : rd_path;

    fslice_path_load #(
        .NUM_PATHS (NUM_PATHS),
        .LEN_W     (LEN_W),
        .LOAD_W    (LOAD_W),
        .PATH_W    (PATH_W)
    ) u_load (
        .clk       (clk),
        .rst       (rst),
        .add_en    (accept),
        .add_path  (pick),
        .add_len   (in_len),
        .dep_valid (dep_valid),
        .dep_len   (dep_len),
        .load_flat (path_load),
        .min_path  (lightest)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.vld <= accept;
            if (accept) begin
                verdict_q.start <= fresh;
                verdict_q.path  <= pick;
            end
        end
    end

    assign out_valid       = verdict_q.vld;
    assign out_slice_start = verdict_q.start;
    assign out_path        = verdict_q.path;
endmodule

// File: rtl/fslice_dispatch_chk.sv
module fslice_dispatch_chk #(
    parameter int NUM_PATHS = 4,
    parameter int FLOW_W    = 32,
    parameter int LOAD_W    = 24,
    parameter int TS_W      = 20,
    localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic [FLOW_W-1:0]           in_flow,
    input logic [TS_W-1:0]             slice_thresh,
    input logic [NUM_PATHS-1:0]        dep_valid,
    input logic                        out_valid,
    input logic [PATH_W-1:0]           out_path,
    input logic                        out_slice_start,
    input logic [NUM_PATHS*LOAD_W-1:0] path_load
);
    logic took;
    assign took = in_valid && in_ready;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (path_load == '0 && !out_valid && !in_ready));

    // R2
    decision_follows_chk: assert property (@(posedge clk) disable iff (rst)
        took |=> out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !took |=> !out_valid);

    // R4
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (took && $past(took) && in_flow == $past(in_flow) && slice_thresh != '0)
        |=> (!out_slice_start && out_path == $past(out_path)));

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_quiet
        // R7
        load_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (!took && !dep_valid[p]) |=> $stable(path_load[p*LOAD_W +: LOAD_W]));
    end
endmodule

bind fslice_dispatch fslice_dispatch_chk #(
    .NUM_PATHS (NUM_PATHS),
    .FLOW_W    (FLOW_W),
    .LOAD_W    (LOAD_W),
    .TS_W      (TS_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .in_flow         (in_flow),
    .slice_thresh    (slice_thresh),
    .dep_valid       (dep_valid),
    .out_valid       (out_valid),
    .out_path        (out_path),
    .out_slice_start (out_slice_start),
    .path_load       (path_load)
);

// File: tb/fslice_dispatch_tb.sv
module fslice_dispatch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int FW  = 32;
    localparam int LW  = 12;
    localparam int LDW = 20;
    localparam int IW  = 6;
    localparam int TW  = 10;
    localparam int PW  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [FW-1:0]     in_flow = '0;
    logic [LW-1:0]     in_len = '0;
    logic [TW-1:0]     slice_thresh = TW'(10);
    logic [NP-1:0]     dep_valid = '0;
    logic [NP*LW-1:0]  dep_len = '0;
    logic              out_valid;
    logic [PW-1:0]     out_path;
    logic              out_slice_start;
    logic [NP*LDW-1:0] path_load;

    int errors = 0;
    int checks = 0;
    int now = 0;

    // reference model
    bit          m_live [1<<IW];
    logic [31:0] m_tag  [1<<IW];
    int          m_last [1<<IW];
    int          m_path [1<<IW];
    longint      m_load [NP];

    fslice_dispatch #(
        .NUM_PATHS (NP), .FLOW_W (FW), .LEN_W (LW),
        .LOAD_W (LDW), .IDX_W (IW), .TS_W (TW)
    ) u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_flow (in_flow), .in_len (in_len), .slice_thresh (slice_thresh),
        .dep_valid (dep_valid), .dep_len (dep_len), .out_valid (out_valid),
        .out_path (out_path), .out_slice_start (out_slice_start),
        .path_load (path_load)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // absolute tick count, no wrap
    always @(posedge clk) begin
        if (rst) now <= 0;
        else     now <= now + 1;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bidx(input logic [31:0] f);
        int r = 0;
        for (int j = 0; j < IW; j++) begin
            bit b = 1'b0;
            for (int i = j; i < FW; i += IW) b ^= f[i];
            r |= int'(b) << j;
        end
        return r;
    endfunction

    function automatic int lightest();
        int best = 0;
        for (int p = 1; p < NP; p++) if (m_load[p] < m_load[best]) best = p;
        return best;
    endfunction

    task automatic check_loads(input string req);
        for (int p = 0; p < NP; p++)
            check(req, $sformatf("load[%0d]", p), longint'(path_load[p*LDW +: LDW]), m_load[p]);
    endtask

    // Drive one packet (without releasing in_valid); at_t < 0 means next negedge
    task automatic send_core(input logic [31:0] f, input int len, input int at_t,
                             input int dp, input int dl, input string req,
                             output bit got_start, output int got_path);
        int ix; int ep; bit en;
        @(negedge clk);
        while (at_t >= 0 && now < at_t) @(negedge clk);
        in_valid = 1'b1; in_flow = f; in_len = LW'(len);
        dep_valid = '0;
        if (dp >= 0) begin
            dep_valid[dp] = 1'b1;
            dep_len[dp*LW +: LW] = LW'(dl);
        end
        ix = bidx(f);
        en = !m_live[ix] || (m_tag[ix] != f) || ((now - m_last[ix]) > int'(slice_thresh));
        ep = en ? lightest() : m_path[ix];
        m_live[ix] = 1'b1; m_tag[ix] = f; m_last[ix] = now; m_path[ix] = ep;
        m_load[ep] += len;
        if (dp >= 0) begin
            m_load[dp] -= dl;
            if (m_load[dp] < 0) m_load[dp] = 0;
        end
        @(posedge clk); #1;
        check("R2", "out_valid", out_valid, 1);
        check(req, "slice_start", out_slice_start, en);
        check(req, "path", out_path, ep);
        check_loads("R7");
        got_start = out_slice_start;
        got_path  = out_path;
    endtask

    task automatic release_in();
        @(negedge clk);
        in_valid = 1'b0; dep_valid = '0;
    endtask

    task automatic send(input logic [31:0] f, input int len, input int at_t, input string req,
                        output bit got_start, output int got_path, output int acc_t);
        acc_t = (at_t < 0) ? now + 1 : at_t;
        send_core(f, len, at_t, -1, 0, req, got_start, got_path);
        release_in();
    endtask

    task automatic depart(input int p, input int dl);
        @(negedge clk);
        dep_valid = '0; dep_valid[p] = 1'b1; dep_len[p*LW +: LW] = LW'(dl);
        m_load[p] -= dl;
        if (m_load[p] < 0) m_load[p] = 0;
        @(posedge clk); #1;
        check_loads("R8");
        @(negedge clk);
        dep_valid = '0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1", "in_ready in reset", in_ready, 0);
        check("R1", "out_valid in reset", out_valid, 0);
        check("R1", "loads in reset", longint'(path_load == '0), 1);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_spread();
        bit s; int p; int t;
        // all loads zero: ties resolve upward as loads grow (R3)
        for (int k = 1; k <= 4; k++) begin
            send(32'(k), 100 * k, -1, "R3", s, p, t);
            check("R1", "first packet starts slice", s, 1);
            check("R3", "lightest path", p, k - 1);
        end
        // flow 4 sits on the heaviest path yet must stay there (R4)
        send(32'd4, 50, -1, "R4", s, p, t);
        check("R4", "continuation start", s, 0);
        check("R4", "continuation path", p, 3);
    endtask

    task automatic t_threshold();
        bit s; int p; int t0; int t1; int t2; int t3;
        send(32'd4, 10, -1, "R4", s, p, t0);
        send(32'd4, 10, t0 + 10, "R4", s, p, t1);
        check("R4", "gap equal to threshold keeps slice", s, 0);
        check("R4", "gap equal to threshold path", p, 3);
        send(32'd4, 10, t1 + 11, "R5", s, p, t2);
        check("R5", "gap above threshold opens slice", s, 1);
        slice_thresh = TW'(3);
        send(32'd4, 10, t2 + 3, "R5", s, p, t3);
        check("R5", "new threshold, gap 3", s, 0);
        send(32'd4, 10, t3 + 4, "R5", s, p, t3);
        check("R5", "new threshold, gap 4", s, 1);
        slice_thresh = TW'(10);
    endtask

    task automatic t_alias();
        bit s; int p; int t;
        send(32'd1, 20, -1, "R6", s, p, t);
        // 0x40 folds onto the same index as flow 1
        send(32'h40, 20, -1, "R6", s, p, t);
        check("R6", "alias opens slice", s, 1);
        send(32'd1, 20, -1, "R6", s, p, t);
        check("R6", "evicted flow reopens", s, 1);
        send(32'd1, 20, -1, "R6", s, p, t);
        check("R6", "replaced entry continues", s, 0);
    endtask

    task automatic t_back_to_back();
        bit s0; bit s1; bit s2; int p0; int p1; int p2;
        send_core(32'd7, 30, -1, -1, 0, "R4", s0, p0);
        send_core(32'd7, 30, -1, -1, 0, "R4", s1, p1);
        send_core(32'd7, 30, -1, -1, 0, "R4", s2, p2);
        release_in();
        check("R4", "b2b second start", s1, 0);
        check("R4", "b2b third start", s2, 0);
        check("R4", "b2b second path", p1, p0);
        check("R4", "b2b third path", p2, p0);
        @(posedge clk); #1;
        check("R2", "out_valid after idle edge", out_valid, 0);
    endtask

    task automatic t_departures();
        bit s; int p;
        depart(3, 100);
        depart(0, 4000);
        check("R8", "underflow clamps to zero", longint'(path_load[0 +: LDW]), 0);
        // path 0 is empty, so a new flow lands there together with a departure
        send_core(32'd11, 300, -1, 0, 100, "R8", s, p);
        release_in();
        check("R8", "combined path", p, 0);
        check("R8", "add then subtract", longint'(path_load[0 +: LDW]), 200);
    endtask

    task automatic t_wrap();
        bit s; int p; int t0; int t1; int tw;
        tw = ((now / (1 << TW)) + 1) * (1 << TW) - 3;
        send(32'd9, 40, tw, "R9", s, p, t0);
        send(32'd9, 40, t0 + 6, "R9", s, p, t1);
        check("R9", "gap across wrap continues", s, 0);
        send(32'd9, 40, t1 + 40, "R9", s, p, t0);
        check("R9", "long gap after wrap re-slices", s, 1);
    endtask

    initial begin
        for (int i = 0; i < (1 << IW); i++) m_live[i] = 1'b0;
        for (int p = 0; p < NP; p++) m_load[p] = 0;
        t_reset();
        t_spread();
        t_threshold();
        t_alias();
        t_back_to_back();
        t_departures();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual=hung expected=complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule